// File: doc/BRIEF.md
# Full-Slot Bus Transfer Packer

This block collects data words that arrive from a memory-side source and hands them to a system bus that carries four data slots in each bus cycle. The source supplies words in bursts or at an irregular rate, one word per channel per clock, each marked by its own valid strobe. The packer keeps the words in a small in-order buffer. It offers a bus transfer only when a whole four-word group is waiting, so every transfer on the bus is full from its first slot to its last. When the source is slower than the bus, the bus sees empty cycles and never a transfer that runs dry part-way.

A second input channel can be switched on, so that the buffer fills up to two words per clock, twice the single-channel rate. When both channels deliver in the same clock, the word on channel 0 counts as older than the word on channel 1. A flow-control output tells the source to hold off while the buffer is nearly full. A saturating counter records each cycle in which the bus was ready but no full group was waiting.

Top module: `packer_top`

## Requirements
- R1: After reset, `out_valid` and `in_stall` are low and `bubble_cnt` is zero.
- R2: `out_valid` is high exactly when at least four words are buffered. With fewer than four words buffered, no transfer is offered, whatever the state of `bus_rdy`.
- R3: `out_data` carries the four oldest buffered words in arrival order. Bits [63:0] (slot 0) hold the oldest word and bits [255:192] (slot 3) hold the fourth oldest.
- R4: A transfer takes place on a clock edge where `out_valid` and `bus_rdy` are both high, and it removes exactly four words from the buffer.
- R5: `bubble_cnt` goes up by one on each clock edge where `bus_rdy` is high and `out_valid` is low. It stops at its all-ones value.
- R6: With `dual_en` high, each channel can write one word per clock. When both channels write in the same clock, the word on channel 0 is placed ahead of the word on channel 1.
- R7: With `dual_en` low, `ch1_vld` and `ch1_data` have no effect on the buffer.
- R8: `in_stall` is high while fewer than two buffer entries are free. Words presented while `in_stall` is high are dropped.
- R9: A word becomes part of the buffer count on the clock edge that accepts it. `out_valid` can therefore rise in the cycle right after the edge that brings in the fourth word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_en | input | 1 | Enables the second input channel |
| ch0_vld | input | 1 | Channel 0 word strobe |
| ch0_data | input | 64 | Channel 0 word |
| ch1_vld | input | 1 | Channel 1 word strobe |
| ch1_data | input | 64 | Channel 1 word |
| in_stall | output | 1 | Source must hold off: fewer than two free entries |
| bus_rdy | input | 1 | Bus can take a transfer this cycle |
| out_valid | output | 1 | A full four-slot group is offered |
| out_data | output | 256 | Four slots, slot 0 in the low bits |
| bubble_cnt | output | 16 | Saturating count of ready-but-empty bus cycles |

## Verification
A wrong read or write pointer shows up on `out_data` at the next full group: words are swapped, repeated or missing within the four slots. A wrong level count shows up within one clock. In that case `out_valid` appears with fewer than four real words, or stays low after the fourth arrives, or `in_stall` trips at the wrong fill point. A dropped-word fault shows only when the buffer drains. The remainder then falls one word short of a group, so `out_valid` stays low at a point where it should be high.

// File: rtl/pack_pkg.sv
package pack_pkg;

  // free entries left in the buffer
  function automatic int free_entries(int depth, int lvl);
    return depth - lvl;
  endfunction

  // source must pause when headroom is below the limit
  function automatic logic stall_needed(int depth, int lvl, int room);
    return free_entries(depth, lvl) < room;
  endfunction

  // a full group is waiting
  function automatic logic group_ready(int lvl, int slots);
    return lvl >= slots;
  endfunction

  // number of words accepted this cycle (0..2)
  function automatic logic [1:0] words_in(logic a, logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction

endpackage

// File: rtl/slot_fifo.sv
module slot_fifo import pack_pkg::*; #(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  parameter int SLOTS = 4,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr0,
  input  logic [W-1:0]         d0,
  input  logic                 wr1,
  input  logic [W-1:0]         d1,
  input  logic                 pop,
  output logic [LVL_W-1:0]     level,
  output logic [SLOTS*W-1:0]   rd_words
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nx1, d1_idx;
  logic [1:0]       n_in;

  assign n_in       = words_in(wr0, wr1);
  assign wr_ptr_nx1 = wr_ptr + PTR_W'(1);
  assign d1_idx     = wr0 ? wr_ptr_nx1 : wr_ptr;

  always_ff @(posedge clk) begin
    if (wr0) mem[wr_ptr] <= d0;
    if (wr1) mem[d1_idx] <= d1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(n_in);
      if (pop) rd_ptr <= rd_ptr + PTR_W'(SLOTS);
      level  <= LVL_W'(int'(level) + int'(n_in) - (pop ? SLOTS : 0));
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign rd_words[g*W +: W] = mem[rd_ptr + PTR_W'(g)];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH); // R8

  AST_POP_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> int'(level) >= SLOTS); // R2

  AST_POP_TAKES_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> int'(level) == int'($past(level)) + int'($past(n_in)) - SLOTS); // R4

endmodule

// File: rtl/bubble_ctr.sv
module bubble_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '0;
    else if (hit && count != TOP) count <= count + CW'(1);
  end

  AST_BUBBLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && count != TOP) |=> count == $past(count) + CW'(1)); // R5

  AST_BUBBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit || count == TOP) |=> $stable(count)); // R5

endmodule

// File: rtl/packer_top.sv
module packer_top import pack_pkg::*; #(
  parameter int DATA_W     = 64,
  parameter int FIFO_DEPTH = 16,
  parameter int SLOTS      = 4,
  parameter int HEADROOM   = 2,
  parameter int BUB_W      = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dual_en,
  input  logic                     ch0_vld,
  input  logic [DATA_W-1:0]        ch0_data,
  input  logic                     ch1_vld,
  input  logic [DATA_W-1:0]        ch1_data,
  output logic                     in_stall,
  input  logic                     bus_rdy,
  output logic                     out_valid,
  output logic [SLOTS*DATA_W-1:0]  out_data,
  output logic [BUB_W-1:0]         bubble_cnt
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic [LVL_W-1:0] level;
  logic             acc0, acc1, fire, bub_hit;
  logic [1:0]       push_n;

  assign in_stall  = stall_needed(FIFO_DEPTH, int'(level), HEADROOM);
  assign out_valid = group_ready(int'(level), SLOTS);
  assign acc0      = ch0_vld && !in_stall;
  assign acc1      = ch1_vld && dual_en && !in_stall;
  assign push_n    = words_in(acc0, acc1);
  assign fire      = out_valid && bus_rdy;
  assign bub_hit   = bus_rdy && !out_valid;

  slot_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .SLOTS(SLOTS), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr0(acc0), .d0(ch0_data),
    .wr1(acc1), .d1(ch1_data),
    .pop(fire), .level(level), .rd_words(out_data)
  );

  bubble_ctr #(.CW(BUB_W)) u_bub (
    .clk(clk), .rst_n(rst_n), .hit(bub_hit), .count(bubble_cnt)
  );

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    in_stall |-> push_n == 2'd0); // R8

  AST_SINGLE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_en |-> push_n <= 2'd1); // R7

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> int'(level) == int'($past(level)) + int'($past(push_n))); // R9

endmodule

// File: tb/tb_packer_top.sv
module tb_packer_top;
  logic         clk = 0;
  logic         rst_n, dual_en, ch0_vld, ch1_vld, bus_rdy;
  logic [63:0]  ch0_data, ch1_data;
  logic         in_stall, out_valid;
  logic [255:0] out_data;
  logic [15:0]  bubble_cnt;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  packer_top dut (
    .clk(clk), .rst_n(rst_n), .dual_en(dual_en),
    .ch0_vld(ch0_vld), .ch0_data(ch0_data),
    .ch1_vld(ch1_vld), .ch1_data(ch1_data),
    .in_stall(in_stall), .bus_rdy(bus_rdy),
    .out_valid(out_valid), .out_data(out_data), .bubble_cnt(bubble_cnt)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_group(input string tag, input logic [63:0] a, b, c, d);
    chk({tag, " valid"}, 64'(out_valid), 64'd1);
    chk({tag, " slot0"}, out_data[63:0],    a);
    chk({tag, " slot1"}, out_data[127:64],  b);
    chk({tag, " slot2"}, out_data[191:128], c);
    chk({tag, " slot3"}, out_data[255:192], d);
  endtask

  task automatic do_reset();
    rst_n = 0; dual_en = 0; ch0_vld = 0; ch1_vld = 0; bus_rdy = 0;
    ch0_data = '0; ch1_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // one clock with the given inputs, back at the following negedge
  task automatic cyc(input logic v0, input logic [63:0] w0, input logic v1, input logic [63:0] w1);
    ch0_vld = v0; ch0_data = w0; ch1_vld = v1; ch1_data = w1;
    @(negedge clk);
    ch0_vld = 0; ch1_vld = 0;
  endtask

  task automatic pop_once();
    bus_rdy = 1;
    @(negedge clk);
    bus_rdy = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 in_stall", 64'(in_stall), 64'd0);
    chk("R1 bubble_cnt", 64'(bubble_cnt), 64'd0);
  endtask

  task automatic t_single();
    do_reset();
    for (int i = 0; i < 3; i++) begin
      cyc(1, 64'hA0 + 64'(i), 0, '0);
      chk("R2 partial held", 64'(out_valid), 64'd0);
    end
    cyc(1, 64'hA3, 0, '0);
    chk_group("R3 R9 group", 64'hA0, 64'hA1, 64'hA2, 64'hA3);
    @(negedge clk);
    chk("R2 held without bus_rdy", 64'(out_valid), 64'd1);
    pop_once();
    chk("R4 group removed", 64'(out_valid), 64'd0);
    chk("R5 no bubble on transfer", 64'(bubble_cnt), 64'd0);
  endtask

  task automatic t_bubbles();
    do_reset();
    bus_rdy = 1;
    repeat (5) @(negedge clk);
    chk("R5 idle bubbles", 64'(bubble_cnt), 64'd5);
    for (int i = 0; i < 4; i++) begin
      cyc(1, 64'hB0 + 64'(i), 0, '0);
      if (i < 3) begin
        chk("R2 slow source", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk("R2 slow source gap", 64'(out_valid), 64'd0);
      end
    end
    bus_rdy = 0;
    chk("R5 bubbles while filling", 64'(bubble_cnt), 64'd12);
    chk_group("R3 slow group", 64'hB0, 64'hB1, 64'hB2, 64'hB3);
    pop_once();
    chk("R4 drained", 64'(out_valid), 64'd0);
    chk("R5 count kept", 64'(bubble_cnt), 64'd12);
  endtask

  task automatic t_saturate();
    do_reset();
    bus_rdy = 1;
    repeat (65535) @(negedge clk);
    chk("R5 reaches top", 64'(bubble_cnt), 64'hFFFF);
    repeat (3) @(negedge clk);
    bus_rdy = 0;
    chk("R5 saturates", 64'(bubble_cnt), 64'hFFFF);
  endtask

  task automatic t_dual();
    do_reset();
    dual_en = 1;
    cyc(1, 64'hC0, 1, 64'hC1);
    chk("R6 two words not yet group", 64'(out_valid), 64'd0);
    cyc(1, 64'hC2, 1, 64'hC3);
    chk_group("R6 dual order", 64'hC0, 64'hC1, 64'hC2, 64'hC3);
    pop_once();
    cyc(0, '0, 1, 64'hD0);
    cyc(1, 64'hD1, 1, 64'hD2);
    cyc(1, 64'hD3, 0, '0);
    chk_group("R6 mixed order", 64'hD0, 64'hD1, 64'hD2, 64'hD3);
  endtask

  task automatic t_ch1_off();
    do_reset();
    dual_en = 0;
    for (int i = 0; i < 4; i++) cyc(0, '0, 1, 64'hE0 + 64'(i));
    chk("R7 ch1 ignored", 64'(out_valid), 64'd0);
    for (int i = 0; i < 4; i++) cyc(1, 64'hF0 + 64'(i), 1, 64'hEE);
    chk_group("R7 only ch0 words", 64'hF0, 64'hF1, 64'hF2, 64'hF3);
  endtask

  task automatic t_stall();
    do_reset();
    for (int i = 0; i < 14; i++) cyc(1, 64'h100 + 64'(i), 0, '0);
    chk("R8 two free no stall", 64'(in_stall), 64'd0);
    cyc(1, 64'h10E, 0, '0);
    chk("R8 one free stalls", 64'(in_stall), 64'd1);
    cyc(1, 64'hDEAD, 0, '0);
    chk_group("R8 g0", 64'h100, 64'h101, 64'h102, 64'h103);
    pop_once();
    chk("R8 stall released", 64'(in_stall), 64'd0);
    chk_group("R8 g1", 64'h104, 64'h105, 64'h106, 64'h107);
    pop_once();
    chk_group("R8 g2", 64'h108, 64'h109, 64'h10A, 64'h10B);
    pop_once();
    chk("R8 stalled word dropped", 64'(out_valid), 64'd0);
    cyc(1, 64'h10F, 0, '0);
    chk_group("R8 tail", 64'h10C, 64'h10D, 64'h10E, 64'h10F);
  endtask

  bit done = 0;

  initial begin
    t_reset();
    t_single();
    t_bubbles();
    t_dual();
    t_ch1_off();
    t_stall();
    t_saturate();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule